// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block produces the fetch address of a small 8-bit core. The program address is 13 bits wide, so the program memory holds 8192 words. That space is split into 8 pages of 1024 words each. Every cycle the block takes one command from the decoder and moves the counter. The command can hold the counter, step it by one, or load a branch target. It can also call a subroutine or return from one, either an ordinary return or a return from interrupt. A separate strobe takes an interrupt and sends the core to a vector in page 0.

Jumps, calls and direct writes to the counter take the upper 3 address bits from an external page-select register, and the lower 10 bits from the immediate. A return instead restores all 13 bits from an 8-level circular return stack, so control comes back to the caller's page whatever the page select holds at that moment. A one-cycle flag tells the core that the counter has been redirected and that the fetch pipeline needs an extra cycle.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next cycle shows `fetch_addr` = 0 and `extra_cycle` = 0, and the stack is emptied.
- R2: Command code 1 (step) advances `fetch_addr` by one and wraps from 8191 to 0. Codes 0 and 7 (hold) leave it unchanged.
- R3: Codes 2 (jump) and 5 (direct counter write) load `fetch_addr` with `{page_sel, imm}`, with `page_sel` in bits 12..10.
- R4: Code 3 (call) pushes `fetch_addr + 1` onto the stack and loads `{page_sel, imm}`.
- R5: Codes 4 (return) and 6 (return from interrupt) load all 13 bits from the top of the stack, and `page_sel` has no effect on the result.
- R6: Returns deliver the pushed addresses in last-in, first-out order for up to 8 nested levels.
- R7: A push onto a stack that holds 8 entries overwrites the oldest entry. After 9 pushes, 8 returns give the 8 newest addresses, newest first.
- R8: A return on an empty stack loads the address most recently read from the stack, or 0 if none has been read since reset. It raises no error.
- R9: When `irq_take` is high, `fetch_addr` becomes `{3'b000, irq_vec}`. The address that the same cycle's command would have produced is pushed as the return address.
- R10: When a jump, call or return coincides with `irq_take`, that command completes first, and its target is the address pushed for the interrupt. A call plus an interrupt pushes two entries: the call's return address first, then the call target.
- R11: `extra_cycle` is 1 in the cycle after a command with code 2 to 6 or an interrupt entry, and 0 after any other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 3 | Sequencer command: 0 hold, 1 step, 2 jump, 3 call, 4 return, 5 direct write, 6 return from interrupt, 7 hold |
| page_sel | input | 3 | Page-select register contents |
| imm | input | 10 | In-page target offset |
| irq_take | input | 1 | Interrupt entry this cycle |
| irq_vec | input | 10 | Vector offset within page 0 |
| fetch_addr | output | 13 | Current program counter / fetch address |
| extra_cycle | output | 1 | Counter was redirected last cycle |

## Verification
Two stack edges are hard to reach from the ports: overwriting the oldest level after 9 nested calls, and popping an empty stack. Random traffic seldom drives the depth that far in either direction. Directed sequences therefore run 9 calls followed by 10 returns, and they place interrupts on the same cycle as a call, a return and a step. After that, a seeded random mix with call and return weights runs against a bench model of the stack and the counter. The final state of that random mix is disturbed by a reset partway through.

// File: rtl/pcs_pkg.sv
// Shared command encoding for the paged program counter sequencer.
package pcs_pkg;
    typedef enum logic [2:0] {
        PC_HOLD = 3'd0,
        PC_INC  = 3'd1,
        PC_JMP  = 3'd2,
        PC_CALL = 3'd3,
        PC_RET  = 3'd4,
        PC_WRPC = 3'd5,
        PC_RETI = 3'd6,
        PC_RSVD = 3'd7
    } pc_cmd_e;
endpackage

// File: rtl/pcs_target.sv
// Next-address selector: decodes one command into the address it produces
// and the stack actions it needs. Purely combinational.
// Assumes pop_val already holds the value a pop would return this cycle.
module pcs_target #(
    parameter int PAGE_W = 3,
    parameter int OFFS_W = 10,
    localparam int ADDR_W = PAGE_W + OFFS_W
) (
    input  logic [2:0]        cmd,
    input  logic [ADDR_W-1:0] pc,
    input  logic [PAGE_W-1:0] page_sel,
    input  logic [OFFS_W-1:0] imm,
    input  logic [ADDR_W-1:0] pop_val,
    output logic [ADDR_W-1:0] nxt,
    output logic              changes,
    output logic              do_call,
    output logic              do_pop
);
    import pcs_pkg::*;

    // Select the produced address and the side effects per command.
    always_comb begin
        nxt     = pc;
        changes = 1'b0;
        do_call = 1'b0;
        do_pop  = 1'b0;
        case (pc_cmd_e'(cmd))
            PC_INC:  nxt = pc + ADDR_W'(1);
            PC_JMP, PC_WRPC: begin
                nxt     = {page_sel, imm};
                changes = 1'b1;
            end
            PC_CALL: begin
                nxt     = {page_sel, imm};
                changes = 1'b1;
                do_call = 1'b1;
            end
            PC_RET, PC_RETI: begin
                nxt     = pop_val;
                changes = 1'b1;
                do_pop  = 1'b1;
            end
            default: nxt = pc;
        endcase
    end
endmodule

// File: rtl/pcs_stack.sv
// Circular return stack. In one cycle it may pop once and then push zero,
// one or two values (push_a first). Pushing onto a full stack overwrites the
// oldest entry; popping an empty stack returns the last value read.
// Assumes DEPTH is a power of two so the pointer wraps naturally.
module pcs_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 13,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pop,
    input  logic [1:0]   push_n,
    input  logic [W-1:0] push_a,
    input  logic [W-1:0] push_b,
    output logic [W-1:0] pop_val
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] ptr;
    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     last_rd;
    logic [PTR_W-1:0] ptr_ap;
    logic [CNT_W-1:0] cnt_ap;
    logic [CNT_W:0]   cnt_sum;
    logic [PTR_W-1:0] wa0, wa1;

    // Value a pop would return, and the state after the pop.
    always_comb begin
        pop_val = (cnt != '0) ? mem[ptr - PTR_W'(1)] : last_rd;
        ptr_ap  = (pop && cnt != '0) ? ptr - PTR_W'(1) : ptr;
        cnt_ap  = (pop && cnt != '0) ? cnt - CNT_W'(1) : cnt;
        wa0     = ptr_ap;
        wa1     = ptr_ap + PTR_W'(1);
        cnt_sum = {1'b0, cnt_ap} + (CNT_W + 1)'(push_n);
    end

    // Pointer, fill count and last-read register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr     <= '0;
            cnt     <= '0;
            last_rd <= '0;
        end else begin
            ptr <= ptr_ap + PTR_W'(push_n);
            cnt <= (cnt_sum > (CNT_W + 1)'(DEPTH)) ? CNT_W'(DEPTH) : cnt_sum[CNT_W-1:0];
            if (pop) last_rd <= pop_val;
        end
    end

    // One write port per entry, picked by the two push slots.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst_n && push_n == 2'd2 && wa1 == PTR_W'(i))
                mem[i] <= push_b;
            else if (rst_n && push_n != 2'd0 && wa0 == PTR_W'(i))
                mem[i] <= push_a;
        end
    end
endmodule

// File: rtl/pc_sequencer.sv
// Paged program counter with return stack and interrupt entry.
// The command target is resolved first; an interrupt then pushes that target
// and redirects to its vector in page 0. Assumes one command per cycle.
module pc_sequencer #(
    parameter int PAGE_W = 3,
    parameter int OFFS_W = 10,
    parameter int DEPTH  = 8,
    localparam int ADDR_W = PAGE_W + OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd,
    input  logic [PAGE_W-1:0] page_sel,
    input  logic [OFFS_W-1:0] imm,
    input  logic              irq_take,
    input  logic [OFFS_W-1:0] irq_vec,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              extra_cycle
);
    logic [ADDR_W-1:0] pc_q, nxt, pop_val, ret_addr, push_a;
    logic              changes, do_call, do_pop;
    logic [1:0]        push_n;

    pcs_target #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W)) u_target (
        .cmd(cmd), .pc(pc_q), .page_sel(page_sel), .imm(imm),
        .pop_val(pop_val), .nxt(nxt), .changes(changes),
        .do_call(do_call), .do_pop(do_pop)
    );

    // Stack push requests: call return address first, then interrupt return.
    always_comb begin
        ret_addr = pc_q + ADDR_W'(1);
        push_n   = {1'b0, do_call} + {1'b0, irq_take};
        push_a   = do_call ? ret_addr : nxt;
    end

    pcs_stack #(.DEPTH(DEPTH), .W(ADDR_W)) u_stack (
        .clk(clk), .rst_n(rst_n), .pop(do_pop), .push_n(push_n),
        .push_a(push_a), .push_b(nxt), .pop_val(pop_val)
    );

    // Counter and redirect flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q        <= '0;
            extra_cycle <= 1'b0;
        end else begin
            pc_q        <= irq_take ? {PAGE_W'(0), irq_vec} : nxt;
            extra_cycle <= changes | irq_take;
        end
    end

    assign fetch_addr = pc_q;
endmodule

// File: rtl/pcs_checker.sv
// Port-level properties of the sequencer, bound onto every instance.
module pcs_checker #(
    parameter int PAGE_W = 3,
    parameter int OFFS_W = 10,
    localparam int ADDR_W = PAGE_W + OFFS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cmd,
    input logic [PAGE_W-1:0] page_sel,
    input logic [OFFS_W-1:0] imm,
    input logic              irq_take,
    input logic [OFFS_W-1:0] irq_vec,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              extra_cycle
);
    logic redirect;
    assign redirect = (cmd >= 3'd2) && (cmd <= 3'd6);

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd1 && !irq_take) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(1));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == 3'd0 || cmd == 3'd7) && !irq_take) |=> $stable(fetch_addr));
    assert_jump_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == 3'd2 || cmd == 3'd5) && !irq_take) |=> fetch_addr == {$past(page_sel), $past(imm)});
    assert_call_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd3 && !irq_take) |=> fetch_addr == {$past(page_sel), $past(imm)});
    assert_irq_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> fetch_addr == {PAGE_W'(0), $past(irq_vec)});
    assert_extra_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect || irq_take) |=> extra_cycle);
    assert_extra_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect && !irq_take) |=> !extra_cycle);
endmodule

bind pc_sequencer pcs_checker #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W)) u_pcs_checker (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .page_sel(page_sel), .imm(imm),
    .irq_take(irq_take), .irq_vec(irq_vec), .fetch_addr(fetch_addr),
    .extra_cycle(extra_cycle)
);

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  cmd;
    logic [2:0]  page_sel;
    logic [9:0]  imm;
    logic        irq_take;
    logic [9:0]  irq_vec;
    logic [12:0] fetch_addr;
    logic        extra_cycle;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference state built from the requirements.
    logic [12:0] m_pc;
    logic [12:0] m_stk [8];
    int          m_ptr, m_cnt;
    logic [12:0] m_last;
    logic        m_extra;

    always #2 clk = ~clk;

    pc_sequencer u_pc_sequencer (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .page_sel(page_sel), .imm(imm),
        .irq_take(irq_take), .irq_vec(irq_vec), .fetch_addr(fetch_addr),
        .extra_cycle(extra_cycle)
    );

    task automatic m_push(input logic [12:0] v);
        m_stk[m_ptr] = v;
        m_ptr = (m_ptr + 1) % 8;
        if (m_cnt < 8) m_cnt++;
    endtask

    task automatic m_reset();
        m_pc = '0; m_ptr = 0; m_cnt = 0; m_last = '0; m_extra = 1'b0;
    endtask

    task automatic m_step(input logic [2:0] c, input logic [2:0] pg, input logic [9:0] im,
                          input logic irq, input logic [9:0] vec);
        logic [12:0] nxt;
        logic chg;
        nxt = m_pc; chg = 1'b0;
        case (c)
            3'd1: nxt = m_pc + 13'd1;
            3'd2, 3'd5: begin nxt = {pg, im}; chg = 1'b1; end
            3'd3: begin nxt = {pg, im}; chg = 1'b1; m_push(m_pc + 13'd1); end
            3'd4, 3'd6: begin
                if (m_cnt > 0) begin
                    m_ptr = (m_ptr + 7) % 8;
                    m_cnt--;
                    m_last = m_stk[m_ptr];
                end
                nxt = m_last; chg = 1'b1;
            end
            default: nxt = m_pc;
        endcase
        if (irq) m_push(nxt);
        m_pc = irq ? {3'b000, vec} : nxt;
        m_extra = chg | irq;
    endtask

    task automatic check(input string tag);
        n_cmp++;
        if (fetch_addr !== m_pc) begin
            n_bad++;
            $display("FAIL %s fetch_addr actual %h expected %h", tag, fetch_addr, m_pc);
        end
        n_cmp++;
        if (extra_cycle !== m_extra) begin
            n_bad++;
            $display("FAIL R11 extra_cycle actual %b expected %b (%s)", extra_cycle, m_extra, tag);
        end
    endtask

    // One clock: drive at negedge, model, sample at the following negedge.
    task automatic step(input logic [2:0] c, input logic [2:0] pg, input logic [9:0] im,
                        input logic irq, input logic [9:0] vec, input string tag);
        cmd = c; page_sel = pg; imm = im; irq_take = irq; irq_vec = vec;
        m_step(c, pg, im, irq, vec);
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic do_reset(input int cycles);
        rst_n = 1'b0; cmd = 3'd2; page_sel = 3'd5; imm = 10'h155; irq_take = 1'b1; irq_vec = 10'h3;
        repeat (cycles) @(posedge clk);
        @(negedge clk);
        m_reset();
        check("R1");
        rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd4711);
        @(negedge clk);
        do_reset(3);
        // R8: return on a fresh stack yields 0
        step(3'd4, 3'd6, 10'h2AA, 1'b0, '0, "R8");
        // R2: hold, then step across the top of memory
        step(3'd0, 3'd1, 10'h001, 1'b0, '0, "R2");
        step(3'd2, 3'd7, 10'h3FF, 1'b0, '0, "R3");
        step(3'd1, 3'd0, 10'h000, 1'b0, '0, "R2");
        step(3'd7, 3'd3, 10'h010, 1'b0, '0, "R2");
        step(3'd5, 3'd4, 10'h123, 1'b0, '0, "R3");
        // R6/R7: nine nested calls on changing pages, then ten returns
        for (int i = 0; i < 9; i++)
            step(3'd3, 3'(i), 10'(i * 37 + 5), 1'b0, '0, "R4");
        for (int i = 0; i < 8; i++)
            step((i % 2) ? 3'd6 : 3'd4, 3'(7 - i), 10'h3C3, 1'b0, '0, "R7");
        step(3'd4, 3'd2, 10'h0F0, 1'b0, '0, "R8");
        step(3'd4, 3'd5, 10'h00F, 1'b0, '0, "R8");
        // R9/R10: interrupt alone and together with redirecting commands
        step(3'd1, 3'd0, 10'h0, 1'b1, 10'h012, "R9");
        step(3'd3, 3'd6, 10'h2B1, 1'b1, 10'h021, "R10");
        step(3'd4, 3'd1, 10'h000, 1'b0, '0, "R10");
        step(3'd4, 3'd1, 10'h000, 1'b0, '0, "R5");
        step(3'd3, 3'd3, 10'h111, 1'b0, '0, "R4");
        step(3'd4, 3'd0, 10'h000, 1'b1, 10'h036, "R10");
        step(3'd6, 3'd7, 10'h3FF, 1'b0, '0, "R5");
        step(3'd2, 3'd4, 10'h200, 1'b1, 10'h009, "R10");
        step(3'd6, 3'd0, 10'h000, 1'b0, '0, "R5");
        // Seeded random mix, with a reset in the middle
        for (int k = 0; k < 4000; k++) begin
            logic [2:0] c;
            int r;
            if (k == 2000) do_reset(1);
            r = $urandom % 16;
            c = (r < 4) ? 3'd3 : (r < 8) ? ((r % 2) ? 3'd4 : 3'd6) : 3'($urandom % 8);
            step(c, 3'($urandom), 10'($urandom), ($urandom % 8) == 0, 10'($urandom), "R6");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule